// File: doc/BRIEF.md
# Serial Configuration Loader

This block runs on the host side of a board and loads a bitstream into a target programmable device that is configured one bit at a time. A start request first pulls the device's active-low program line low for a fixed time and then releases it. The block then polls the device's init line until it reads high. Next it takes bitstream bytes from a valid/ready byte port and shifts each one out on a data pin, timed by a configuration clock pin. An end-of-stream strobe makes it give one extra clock edge, and then it polls the done line. Each poll is bounded: a fixed number of samples with a fixed gap between them. If the samples run out, the block stops with an error instead of waiting forever.

The configuration clock is raised first. The data pin changes while the clock is high, and the clock is dropped afterwards. Each rising edge therefore latches the bit placed during the previous high phase, so the last bit of the stream is only latched by the extra trailing edge. All pulse widths, poll gaps and clock phases are counted in system clock cycles and set by parameters. Both inputs from the target pass through a two-stage synchroniser before any decision uses them.

Top module: `serial_cfg_loader`

## Requirements
- R1: Out of reset `progN` is 1, `cfgClk` is 0, and `busy`, `byteReady`, `success`, `initTimeout` and `doneTimeout` are all 0.
- R2: A `start` accepted while idle drives `progN` low for exactly PROG_CYC system cycles and then returns it high.
- R3: After release, the synchronised init line is sampled at most POLL_TRIES times, INIT_GAP cycles apart, starting at once. A high sample begins streaming. If every sample is low, `initTimeout` is set and `busy` lasts exactly PROG_CYC + (POLL_TRIES-1)*INIT_GAP + 1 cycles.
- R4: Each byte is sent most-significant bit first. The rising edges of `cfgClk`, from the second one on, latch the stream bits in order.
- R5: `cfgData` changes only at an edge where `cfgClk` was already high in the cycle before, so it never changes while the clock is low.
- R6: Every high phase of `cfgClk` lasts exactly HALF_CYC cycles, and every low phase lasts at least HALF_CYC cycles.
- R7: `byteReady` is high only while the shifter is idle between bytes. One byte is taken per handshake, and a `byteValid` held high during shifting takes nothing extra.
- R8: After N bytes and an end-of-stream strobe, `cfgClk` has exactly 8*N+1 rising edges in the run. The final edge latches the last bit.
- R9: An `endStream` that arrives in the same cycle as the handshake of the last byte still lets that byte shift out in full before the trailing edge.
- R10: After the trailing edge, the synchronised done line is polled up to POLL_TRIES times, DONE_GAP cycles apart. A high sample ends the run with `success` set.
- R11: If every done sample is low, the run ends with `doneTimeout` set.
- R12: When a run ends, `progN` is 1 and `cfgClk` is 0. The status flag stays set until the next accepted `start`, which clears it. A `start` while `busy` is ignored.
- R13: At most one of `success`, `initTimeout` and `doneTimeout` is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration run (honoured only when idle) |
| byteData | input | 8 | Bitstream byte |
| byteValid | input | 1 | `byteData` is valid |
| byteReady | output | 1 | Loader takes a byte this cycle if valid |
| endStream | input | 1 | Strobe: no more bytes follow |
| progN | output | 1 | Active-low program line to the target |
| cfgClk | output | 1 | Configuration clock to the target |
| cfgData | output | 1 | Serial data to the target |
| initIn | input | 1 | Target init line (asynchronous) |
| doneIn | input | 1 | Target done line (asynchronous) |
| busy | output | 1 | A run is in progress |
| success | output | 1 | Last run finished with done high |
| initTimeout | output | 1 | Last run gave up waiting for init |
| doneTimeout | output | 1 | Last run gave up waiting for done |

## Verification
Two events can land in the same cycle: the handshake of the final byte and the end-of-stream strobe. The bench provokes this by raising `endStream` together with the last `byteValid` in the cycle where `byteReady` is high. It judges the result by a model of the target, which counts the rising edges of `cfgClk` and must see exactly 8*N+1 of them. The latched bits must equal the bytes in order, and the run must end with `success`. A second overlap, a `start` pulse during streaming, must leave the edge count and the data unchanged.

// File: rtl/scl_pkg.sv
package scl_pkg;

  // Strobes from the control FSM to the pin datapath
  typedef struct packed {
    logic load;    // capture a new byte, reset bit count
    logic clkHi;   // raise the configuration clock
    logic clkLo;   // drop the configuration clock
    logic putBit;  // drive next MSB onto the data pin
    logic progLo;  // assert the program line
    logic progHi;  // release the program line
  } scl_strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_INIT, S_WAITB, S_HI, S_LO, S_TRAIL, S_DONE
  } scl_state_t;

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/scl_shift.sv
module scl_shift
  import scl_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  scl_strobe_t       strobe,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              progN,
  output logic              cfgClk,
  output logic              cfgData,
  output logic              lastBit
);
  localparam int CW = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shReg;
  logic [CW-1:0]     bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progN   <= 1'b1;
      cfgClk  <= 1'b0;
      cfgData <= 1'b0;
      shReg   <= '0;
      bitCnt  <= '0;
    end else begin
      if (strobe.progLo) progN <= 1'b0;
      if (strobe.progHi) progN <= 1'b1;
      if (strobe.clkHi)  cfgClk <= 1'b1;
      if (strobe.clkLo)  cfgClk <= 1'b0;
      if (strobe.load) begin
        shReg  <= byteIn;
        bitCnt <= '0;
      end else if (strobe.putBit) begin
        cfgData <= shReg[BYTE_W-1];
        shReg   <= {shReg[BYTE_W-2:0], 1'b0};
        bitCnt  <= bitCnt + CW'(1);
      end
    end
  end

  assign lastBit = (bitCnt == CW'(BYTE_W));
endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import scl_pkg::*;
#(
  parameter int PROG_CYC   = 8,
  parameter int INIT_GAP   = 4,
  parameter int DONE_GAP   = 24,
  parameter int HALF_CYC   = 2,
  parameter int POLL_TRIES = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        byteValid,
  input  logic        endStream,
  input  logic        initOk,
  input  logic        doneOk,
  input  logic        lastBit,
  output scl_strobe_t strobe,
  output logic        byteReady,
  output logic        busy,
  output logic        success,
  output logic        initTimeout,
  output logic        doneTimeout
);
  localparam int M1   = (PROG_CYC > INIT_GAP) ? PROG_CYC : INIT_GAP;
  localparam int M2   = (DONE_GAP > HALF_CYC) ? DONE_GAP : HALF_CYC;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int NW   = (POLL_TRIES > 1) ? $clog2(POLL_TRIES) : 1;

  scl_state_t    state, nState;
  logic [TW-1:0] timer, nTimer;
  logic [NW-1:0] tries, nTries;
  logic          pendEnd, nPend;
  logic          setOk, setInitTo, setDoneTo, clrStat;

  always_comb begin
    strobe    = '0;
    nState    = state;
    nTimer    = timer;
    nTries    = tries;
    nPend     = pendEnd;
    setOk     = 1'b0;
    setInitTo = 1'b0;
    setDoneTo = 1'b0;
    clrStat   = 1'b0;
    byteReady = (state == S_WAITB) && !pendEnd;
    if (endStream && (state == S_WAITB || state == S_HI || state == S_LO)) nPend = 1'b1;
    case (state)
      S_IDLE: if (start) begin
        strobe.progLo = 1'b1;
        clrStat = 1'b1;
        nPend   = 1'b0;
        nTimer  = TW'(PROG_CYC - 1);
        nState  = S_PROG;
      end
      S_PROG: if (timer != '0) nTimer = timer - TW'(1);
      else begin
        strobe.progHi = 1'b1;
        nTimer = '0;
        nTries = '0;
        nState = S_INIT;
      end
      S_INIT: if (timer != '0) nTimer = timer - TW'(1);
      else if (initOk) nState = S_WAITB;
      else if (tries == NW'(POLL_TRIES - 1)) begin
        setInitTo = 1'b1;
        strobe.progHi = 1'b1;
        strobe.clkLo  = 1'b1;
        nState = S_IDLE;
      end else begin
        nTries = tries + NW'(1);
        nTimer = TW'(INIT_GAP - 1);
      end
      S_WAITB: if (byteReady && byteValid) begin
        strobe.load  = 1'b1;
        strobe.clkHi = 1'b1;
        nTimer = TW'(HALF_CYC - 1);
        nState = S_HI;
      end else if (pendEnd || endStream) begin
        strobe.clkHi = 1'b1;
        nTimer = TW'(HALF_CYC - 1);
        nState = S_TRAIL;
      end
      S_HI: begin
        if (timer == TW'(HALF_CYC - 1)) strobe.putBit = 1'b1;
        if (timer != '0) nTimer = timer - TW'(1);
        else begin
          strobe.clkLo = 1'b1;
          nTimer = TW'(HALF_CYC - 1);
          nState = S_LO;
        end
      end
      S_LO: if (timer != '0) nTimer = timer - TW'(1);
      else if (lastBit) nState = S_WAITB;
      else begin
        strobe.clkHi = 1'b1;
        nTimer = TW'(HALF_CYC - 1);
        nState = S_HI;
      end
      S_TRAIL: if (timer != '0) nTimer = timer - TW'(1);
      else begin
        strobe.clkLo = 1'b1;
        nTimer = '0;
        nTries = '0;
        nState = S_DONE;
      end
      S_DONE: if (timer != '0) nTimer = timer - TW'(1);
      else if (doneOk) begin
        setOk  = 1'b1;
        nState = S_IDLE;
      end else if (tries == NW'(POLL_TRIES - 1)) begin
        setDoneTo = 1'b1;
        nState = S_IDLE;
      end else begin
        nTries = tries + NW'(1);
        nTimer = TW'(DONE_GAP - 1);
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      timer       <= '0;
      tries       <= '0;
      pendEnd     <= 1'b0;
      success     <= 1'b0;
      initTimeout <= 1'b0;
      doneTimeout <= 1'b0;
    end else begin
      state   <= nState;
      timer   <= nTimer;
      tries   <= nTries;
      pendEnd <= nPend;
      if (clrStat) begin
        success     <= 1'b0;
        initTimeout <= 1'b0;
        doneTimeout <= 1'b0;
      end
      if (setOk)     success     <= 1'b1;
      if (setInitTo) initTimeout <= 1'b1;
      if (setDoneTo) doneTimeout <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import scl_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int INIT_GAP   = 4,
  parameter int DONE_GAP   = 6 * INIT_GAP,
  parameter int PROG_CYC   = 2 * INIT_GAP,
  parameter int HALF_CYC   = 2,
  parameter int POLL_TRIES = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteValid,
  output logic              byteReady,
  input  logic              endStream,
  output logic              progN,
  output logic              cfgClk,
  output logic              cfgData,
  input  logic              initIn,
  input  logic              doneIn,
  output logic              busy,
  output logic              success,
  output logic              initTimeout,
  output logic              doneTimeout
);
  scl_strobe_t strobe;
  logic [1:0]  pinSync;
  logic        lastBit;

  scl_sync #(.WIDTH(2)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({doneIn, initIn}), .syncOut(pinSync)
  );

  scl_ctrl #(
    .PROG_CYC(PROG_CYC), .INIT_GAP(INIT_GAP), .DONE_GAP(DONE_GAP),
    .HALF_CYC(HALF_CYC), .POLL_TRIES(POLL_TRIES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .byteValid(byteValid),
    .endStream(endStream), .initOk(pinSync[0]), .doneOk(pinSync[1]),
    .lastBit(lastBit), .strobe(strobe), .byteReady(byteReady), .busy(busy),
    .success(success), .initTimeout(initTimeout), .doneTimeout(doneTimeout)
  );

  scl_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIn(byteData),
    .progN(progN), .cfgClk(cfgClk), .cfgData(cfgData), .lastBit(lastBit)
  );
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic progN,
  input logic cfgClk,
  input logic cfgData,
  input logic byteReady,
  input logic success,
  input logic initTimeout,
  input logic doneTimeout
);
  // R13
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({success, initTimeout, doneTimeout}));

  // R2
  prog_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !progN |-> busy);

  // R7
  ready_idle_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> (busy && progN && !cfgClk));

  // R5
  data_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgData != $past(cfgData)) |-> $past(cfgClk));

  // R12
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (progN && !cfgClk));

  // R12
  busy_by_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R12
  start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !success && !initTimeout && !doneTimeout));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (.*);

// File: tb/serial_cfg_loader_tb.sv
`timescale 1ns/1ps
module serial_cfg_loader_tb;
  localparam int INIT_GAP = 4;
  localparam int DONE_GAP = 24;
  localparam int PROG_CYC = 8;
  localparam int HALF_CYC = 2;
  localparam int TRIES    = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] byteData = '0;
  logic byteValid = 1'b0;
  logic endStream = 1'b0;
  logic initIn = 1'b0;
  logic doneIn = 1'b0;
  logic byteReady, progN, cfgClk, cfgData, busy, success, initTimeout, doneTimeout;

  always #2 clk = ~clk;

  serial_cfg_loader #(
    .BYTE_W(8), .INIT_GAP(INIT_GAP), .DONE_GAP(DONE_GAP), .PROG_CYC(PROG_CYC),
    .HALF_CYC(HALF_CYC), .POLL_TRIES(TRIES)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .byteData(byteData),
    .byteValid(byteValid), .byteReady(byteReady), .endStream(endStream),
    .progN(progN), .cfgClk(cfgClk), .cfgData(cfgData), .initIn(initIn),
    .doneIn(doneIn), .busy(busy), .success(success),
    .initTimeout(initTimeout), .doneTimeout(doneTimeout)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // target model and monitors
  bit initAllow = 1'b0;
  bit doneAllow = 1'b0;
  bit capClr = 1'b0;
  int expEdges = 0;
  int edgeCnt, accCnt, badData, hiRun, loRun, minHi, minLo;
  logic [63:0] capBits;
  logic prevClk, prevData;

  always @(posedge clk) begin
    initIn <= initAllow && progN;
    doneIn <= doneAllow && (edgeCnt == expEdges);
    prevClk  <= cfgClk;
    prevData <= cfgData;
    if (capClr) begin
      edgeCnt <= 0; accCnt <= 0; badData <= 0; capBits <= '0;
      hiRun <= 0; loRun <= 0; minHi <= 9999; minLo <= 9999;
    end else begin
      if (cfgClk && !prevClk) begin
        capBits <= {capBits[62:0], cfgData};
        edgeCnt <= edgeCnt + 1;
        if (loRun < minLo) minLo <= loRun;
      end
      if (!cfgClk && prevClk && hiRun < minHi) minHi <= hiRun;
      if (cfgClk) begin hiRun <= (prevClk ? hiRun : 0) + 1; end
      else begin loRun <= (prevClk ? 0 : loRun) + 1; end
      if (byteValid && byteReady) accCnt <= accCnt + 1;
      if (cfgData != prevData && !prevClk) badData <= badData + 1;
    end
  end

  task automatic chkEq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] bytes [8];
  int progLowCnt, busyCnt;

  task automatic runCfg(input int n, input bit joinEnd, input bit holdValid, input bit pokeStart);
    logic [63:0] expCat;
    expCat = '0;
    for (int i = 0; i < n; i++) expCat = {expCat[55:0], bytes[i]};
    expEdges = 8 * n + 1;
    @(negedge clk); capClr = 1'b1;
    @(negedge clk); capClr = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    progLowCnt = 0;
    busyCnt = 0;
    for (int i = 0; i < n; i++) begin
      if (holdValid) begin byteValid = 1'b1; byteData = bytes[i]; end
      for (int w = 0; w < 3000 && !byteReady; w++) begin
        if (!progN) progLowCnt++;
        @(negedge clk);
      end
      byteValid = 1'b1;
      byteData  = bytes[i];
      endStream = joinEnd && (i == n - 1);
      @(negedge clk);
      endStream = 1'b0;
      if (!holdValid) byteValid = 1'b0;
      if (pokeStart && i == 0) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    end
    byteValid = 1'b0;
    if (!joinEnd) begin endStream = 1'b1; @(negedge clk); endStream = 1'b0; end
    for (int w = 0; w < 5000 && busy; w++) @(negedge clk);
    @(negedge clk);
    if (n > 0) chkEq("R4 bits MSB first", capBits & ((64'd1 << (8 * n)) - 1), expCat);
    chkEq("R8 rising edge count", edgeCnt, expEdges);
    chkEq("R5 data change while clock low", badData, 0);
    chkEq("R6 high phase width", minHi, HALF_CYC);
    chkEq("R6 low phase at least half", (minLo >= HALF_CYC), 1);
    chkEq("R7 handshakes", accCnt, n);
    chkEq("R10 success", success, 1);
    chkEq("R12 pins after run", {progN, cfgClk, busy}, 3'b100);
  endtask

  task automatic tReset;
    chkEq("R1 reset pins", {progN, cfgClk, busy, byteReady}, 4'b1000);
    chkEq("R1 reset status", {success, initTimeout, doneTimeout}, 3'b000);
  endtask

  task automatic tNormal;
    initAllow = 1'b1; doneAllow = 1'b1;
    bytes[0] = 8'hA5; bytes[1] = 8'h3C; bytes[2] = 8'h81;
    runCfg(3, 1'b0, 1'b0, 1'b0);
    chkEq("R2 program low width", progLowCnt, PROG_CYC);
  endtask

  task automatic tHoldValid;
    initAllow = 1'b1; doneAllow = 1'b1;
    bytes[0] = 8'h01; bytes[1] = 8'hFE; bytes[2] = 8'h5A; bytes[3] = 8'h80;
    runCfg(4, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic tJoinEnd;
    initAllow = 1'b1; doneAllow = 1'b1;
    bytes[0] = 8'hC3; bytes[1] = 8'h7E;
    runCfg(2, 1'b1, 1'b0, 1'b0);
    chkEq("R9 joined end success", success, 1);
  endtask

  task automatic tStartWhileBusy;
    initAllow = 1'b1; doneAllow = 1'b1;
    bytes[0] = 8'h96; bytes[1] = 8'h69; bytes[2] = 8'hF0;
    runCfg(3, 1'b0, 1'b0, 1'b1);
    chkEq("R12 start while busy ignored", edgeCnt, 25);
  endtask

  task automatic tInitTimeout;
    initAllow = 1'b0; doneAllow = 1'b0;
    @(negedge clk); capClr = 1'b1;
    @(negedge clk); capClr = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    busyCnt = 0;
    for (int w = 0; w < 5000 && busy; w++) begin busyCnt++; @(negedge clk); end
    chkEq("R3 init poll duration", busyCnt, PROG_CYC + (TRIES - 1) * INIT_GAP + 1);
    chkEq("R3 init timeout flag", {success, initTimeout, doneTimeout}, 3'b010);
    chkEq("R12 pins after init timeout", {progN, cfgClk, byteReady}, 3'b100);
    chkEq("R3 no clock edges", edgeCnt, 0);
    repeat (20) @(negedge clk);
    chkEq("R12 error held", initTimeout, 1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chkEq("R12 start clears error", {initTimeout, busy}, 2'b01);
    for (int w = 0; w < 5000 && busy; w++) @(negedge clk);
  endtask

  task automatic tDoneTimeout;
    initAllow = 1'b1; doneAllow = 1'b0;
    bytes[0] = 8'h42;
    expEdges = 9;
    @(negedge clk); capClr = 1'b1;
    @(negedge clk); capClr = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int w = 0; w < 3000 && !byteReady; w++) @(negedge clk);
    byteValid = 1'b1; byteData = bytes[0];
    @(negedge clk); byteValid = 1'b0;
    endStream = 1'b1;
    @(negedge clk); endStream = 1'b0;
    for (int w = 0; w < 6000 && busy; w++) @(negedge clk);
    chkEq("R11 done timeout flag", {success, initTimeout, doneTimeout}, 3'b001);
    chkEq("R11 edges before done poll", edgeCnt, 9);
    chkEq("R12 pins after done timeout", {progN, cfgClk}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tNormal();
    tHoldValid();
    tJoinEnd();
    tStartWhileBusy();
    tInitTimeout();
    tDoneTimeout();
    tNormal();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule